// File: doc/BRIEF.md
# HI/LO Multiply-Accumulate Unit

This block multiplies two 32-bit operands and places the 64-bit result in a pair of result registers: HI holds the upper word and LO the lower word. Besides plain multiplication it can fold the product into the value already held in HI:LO, by adding it or by subtracting it. Each of the three kinds of operation comes in a signed and an unsigned variant. The variant decides only how the operands are extended before the product is formed. The add and subtract steps themselves wrap modulo 2^64.

An operation starts with a one-cycle strobe that carries the operation code and both operands. These inputs are captured on that edge, so the caller may change them afterwards. The result appears after a fixed latency of `LATENCY` cycles, in the same cycle as a one-cycle done pulse. While an operation is in flight the unit reports busy. It ignores further starts and ignores writes to HI and LO from the move port. When idle, the move port can load HI or LO directly, and both registers can always be read from the outputs.

Top module: `mac_hilo_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, HI, LO, busy and done are all 0.
- R2: Opcode 0 (signed multiply) sign-extends both operands to 64 bits. It writes product bits 63:32 to HI and bits 31:0 to LO.
- R3: Opcode 1 (unsigned multiply) zero-extends both operands and writes the 64-bit product to HI:LO.
- R4: Opcode 2 (signed multiply-add) adds the signed product to the 64-bit value {HI,LO} and writes the sum back, modulo 2^64.
- R5: Opcode 3 (unsigned multiply-add) adds the unsigned product to {HI,LO}, modulo 2^64.
- R6: Opcode 4 (signed multiply-subtract) writes {HI,LO} minus the signed product, modulo 2^64.
- R7: Opcode 5 (unsigned multiply-subtract) writes {HI,LO} minus the unsigned product, modulo 2^64.
- R8: A start accepted in cycle t raises done for exactly one cycle, in cycle t+LATENCY. HI and LO show the new result from that cycle on and keep their old values before it. Operands and opcode are sampled only in cycle t.
- R9: busy is high from cycle t+1 through the done cycle. A start that arrives while busy is high has no effect on the result or on the timing, and produces no second done.
- R10: A move write to HI or LO while busy is low shows on the output in the next cycle. A move write while busy is high is discarded.
- R11: A start with opcode 6 or 7 is ignored: busy stays low, no done occurs and HI/LO are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Operation strobe, sampled when idle |
| op | input | 3 | Operation code (0..5 valid) |
| opa | input | W | First operand |
| opb | input | W | Second operand |
| mv_hi_we | input | 1 | Move-port write enable for HI |
| mv_lo_we | input | 1 | Move-port write enable for LO |
| mv_data | input | W | Move-port write data |
| hi | output | W | Upper result word |
| lo | output | W | Lower result word |
| busy | output | 1 | Operation in flight |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situations to reach are the ones where an operation is already in flight and another request arrives: a second start, or a move-port write, landing in the middle of the busy window. A single check of the final result cannot tell whether such a request was dropped or merely overwritten. The stimulus therefore uses multiply-add, whose result depends on the prior HI:LO value, and injects the intruding request two cycles after the start. The bench then checks the done timing, the accumulated value and the absence of a second done pulse.

// File: rtl/mac_hilo_pkg.sv
package mac_hilo_pkg;

  localparam logic [2:0] OP_MUL_S  = 3'd0;
  localparam logic [2:0] OP_MUL_U  = 3'd1;
  localparam logic [2:0] OP_MADD_S = 3'd2;
  localparam logic [2:0] OP_MADD_U = 3'd3;
  localparam logic [2:0] OP_MSUB_S = 3'd4;
  localparam logic [2:0] OP_MSUB_U = 3'd5;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_ADD  = 2'd1,
    ACC_SUB  = 2'd2
  } acc_mode_e;

  // how the product is merged with the held HI:LO value
  function automatic acc_mode_e mode_of(input logic [2:0] code);
    case (code)
      OP_MADD_S, OP_MADD_U: mode_of = ACC_ADD;
      OP_MSUB_S, OP_MSUB_U: mode_of = ACC_SUB;
      default:              mode_of = ACC_NONE;
    endcase
  endfunction

  // even codes are the signed variants
  function automatic logic is_signed(input logic [2:0] code);
    is_signed = ~code[0];
  endfunction

  function automatic logic code_ok(input logic [2:0] code);
    code_ok = (code <= OP_MSUB_U);
  endfunction

endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl #(
  parameter int LATENCY = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic code_valid,
  output logic accept,
  output logic commit,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(LATENCY) + 1;
  localparam logic [CW-1:0] LAST = CW'(LATENCY - 2);
  localparam logic [CW-1:0] TOP  = CW'(LATENCY - 1);

  logic          busy_q, done_q;
  logic [CW-1:0] cnt_q;

  assign accept = start & code_valid & ~busy_q;
  assign commit = busy_q & ~done_q & (cnt_q == LAST);
  assign busy   = busy_q;
  assign done   = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (done_q) begin
        busy_q <= 1'b0;
        done_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
        if (commit) done_q <= 1'b1;
      end
    end
  end

  AST_DONE_INSIDE_BUSY: assert property (@(posedge clk) disable iff (rst)
    done_q |-> busy_q); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q); // R8
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !done_q) |=> busy_q); // R9
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (cnt_q <= TOP)); // R8
  AST_COMMIT_TO_DONE: assert property (@(posedge clk) disable iff (rst)
    commit |=> done_q); // R8

endmodule

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int W       = 32,
  parameter int LATENCY = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           sgn,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] prod
);
  localparam int PW  = 2 * W;
  localparam int DLY = LATENCY - 2;

  logic [W-1:0]  a_q, b_q;
  logic          s_q;
  logic [PW-1:0] xa, xb, raw;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
      s_q <= 1'b0;
    end else if (load) begin
      a_q <= a;
      b_q <= b;
      s_q <= sgn;
    end
  end

  // extension to full result width makes one product serve both variants
  assign xa  = {{W{s_q & a_q[W-1]}}, a_q};
  assign xb  = {{W{s_q & b_q[W-1]}}, b_q};
  assign raw = xa * xb;

  generate
    if (DLY == 0) begin : g_direct
      assign prod = raw;
    end else begin : g_pipe
      logic [PW-1:0] stage_q [DLY];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DLY; i++) stage_q[i] <= '0;
        end else begin
          stage_q[0] <= raw;
          for (int i = 1; i < DLY; i++) stage_q[i] <= stage_q[i-1];
        end
      end
      assign prod = stage_q[DLY-1];
    end
  endgenerate

endmodule

// File: rtl/mac_accum.sv
module mac_accum
  import mac_hilo_pkg::*;
#(
  parameter int W = 32
) (
  input  acc_mode_e      mode,
  input  logic [2*W-1:0] cur,
  input  logic [2*W-1:0] prod,
  output logic [2*W-1:0] nxt
);
  always_comb begin
    case (mode)
      ACC_ADD: nxt = cur + prod;
      ACC_SUB: nxt = cur - prod;
      default: nxt = prod;
    endcase
  end
endmodule

// File: rtl/mac_hilo_unit.sv
module mac_hilo_unit
  import mac_hilo_pkg::*;
#(
  parameter int W       = 32,
  parameter int LATENCY = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [2:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         mv_hi_we,
  input  logic         mv_lo_we,
  input  logic [W-1:0] mv_data,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo,
  output logic         busy,
  output logic         done
);
  localparam int PW = 2 * W;

  logic          accept, commit;
  logic [PW-1:0] prod, acc_next;
  logic [W-1:0]  hi_q, lo_q;
  acc_mode_e     mode_q;

  mac_ctrl #(.LATENCY(LATENCY)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .code_valid(code_ok(op)),
    .accept(accept), .commit(commit), .busy(busy), .done(done)
  );

  mac_mult #(.W(W), .LATENCY(LATENCY)) u_mult (
    .clk(clk), .rst(rst), .load(accept), .sgn(is_signed(op)),
    .a(opa), .b(opb), .prod(prod)
  );

  always_ff @(posedge clk) begin
    if (rst)         mode_q <= ACC_NONE;
    else if (accept) mode_q <= mode_of(op);
  end

  mac_accum #(.W(W)) u_accum (
    .mode(mode_q), .cur({hi_q, lo_q}), .prod(prod), .nxt(acc_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (commit) begin
      {hi_q, lo_q} <= acc_next;
    end else if (!busy) begin
      if (mv_hi_we) hi_q <= mv_data;
      if (mv_lo_we) lo_q <= mv_data;
    end
  end

  assign hi = hi_q;
  assign lo = lo_q;

  AST_HILO_HOLD_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && !commit) |=> ($stable(hi_q) && $stable(lo_q))); // R10
  AST_RESERVED_IDLE: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && (op > 3'd5)) |=> !busy); // R11
  AST_IDLE_NO_MOVE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!busy && !mv_hi_we && !mv_lo_we) |=> ($stable(hi_q) && $stable(lo_q))); // R10
  AST_START_TO_BUSY: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && (op <= 3'd5)) |=> (busy && !done)); // R9

endmodule

// File: tb/mac_hilo_unit_test.sv
module mac_hilo_unit_test;
  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [31:0] opa = '0, opb = '0, mv_data = '0;
  logic        mv_hi_we = 1'b0, mv_lo_we = 1'b0;
  logic [31:0] hi, lo;
  logic        busy, done;

  int total = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [63:0] model = '0;

  always #10 clk = ~clk;

  mac_hilo_unit #(.W(32), .LATENCY(LAT)) uut (
    .clk(clk), .rst(rst), .start(start), .op(op), .opa(opa), .opb(opb),
    .mv_hi_we(mv_hi_we), .mv_lo_we(mv_lo_we), .mv_data(mv_data),
    .hi(hi), .lo(lo), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] expect_of(input logic [2:0] c, input logic [31:0] a,
                                            input logic [31:0] b, input logic [63:0] cur);
    logic [63:0] p;
    if (c[0] == 1'b0) p = 64'(longint'($signed(a)) * longint'($signed(b)));
    else              p = {32'd0, a} * {32'd0, b};
    case (c)
      3'd2, 3'd3: expect_of = cur + p;
      3'd4, 3'd5: expect_of = cur - p;
      default:    expect_of = p;
    endcase
  endfunction

  // disturb: 0 none, 1 second start mid-flight, 2 move write mid-flight
  task automatic run_op(input logic [2:0] c, input logic [31:0] a, input logic [31:0] b,
                        input int disturb, input string tag);
    logic [63:0] exp, old;
    old = model;
    exp = expect_of(c, a, b, model);
    @(negedge clk);
    op = c; opa = a; opb = b; start = 1'b1;
    for (int k = 1; k <= LAT; k++) begin
      @(negedge clk);
      if (k == 1) begin
        start = 1'b0; op = 3'd1; opa = 32'hDEAD_BEEF; opb = 32'h1234_5678;
      end
      if (k == 3) begin
        start = 1'b0; mv_hi_we = 1'b0; mv_lo_we = 1'b0;
      end
      if (k < LAT) begin
        chk(done === 1'b0, {tag, " R8 no early done"}, {63'd0, done}, 64'd0);
        chk(busy === 1'b1, {tag, " R9 busy in flight"}, {63'd0, busy}, 64'd1);
        chk({hi, lo} === old, {tag, " R8 HI/LO held before done"}, {hi, lo}, old);
      end
      if (k == 2 && disturb == 1) begin
        start = 1'b1; op = 3'd0; opa = 32'h7FFF_FFFF; opb = 32'h7FFF_FFFF;
      end
      if (k == 2 && disturb == 2) begin
        mv_hi_we = 1'b1; mv_lo_we = 1'b1; mv_data = 32'hA5A5_A5A5;
      end
    end
    chk(done === 1'b1, {tag, " R8 done at latency"}, {63'd0, done}, 64'd1);
    chk({hi, lo} === exp, tag, {hi, lo}, exp);
    model = exp;
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, {tag, " R8 R9 pulse ends"}, {62'd0, busy, done}, 64'd0);
    if (disturb == 1) begin
      for (int k = 0; k < LAT + 2; k++) begin
        @(negedge clk);
        chk(done === 1'b0 && {hi, lo} === exp, {tag, " R9 no second done"},
            {hi, lo}, exp);
      end
    end
  endtask

  task automatic move(input bit to_hi, input logic [31:0] d, input string tag);
    @(negedge clk);
    mv_data = d; mv_hi_we = to_hi; mv_lo_we = ~to_hi;
    @(negedge clk);
    mv_hi_we = 1'b0; mv_lo_we = 1'b0;
    if (to_hi) model[63:32] = d; else model[31:0] = d;
    chk({hi, lo} === model, tag, {hi, lo}, model);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(hi === '0 && lo === '0, "R1 HI/LO zero in reset", {hi, lo}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(hi === '0 && lo === '0, "R1 HI/LO zero after reset", {hi, lo}, 64'd0);
    chk(busy === 1'b0 && done === 1'b0, "R1 idle after reset", {62'd0, busy, done}, 64'd0);
  endtask

  task automatic t_mul;
    run_op(3'd0, 32'hFFFF_FFFD, 32'd7, 0, "R2 signed -3*7");
    run_op(3'd0, 32'h8000_0000, 32'h8000_0000, 0, "R2 signed min*min");
    run_op(3'd0, 32'h7FFF_FFFF, 32'h8000_0000, 0, "R2 signed max*min");
    run_op(3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R3 unsigned max*max");
    run_op(3'd1, 32'h8000_0000, 32'd2, 0, "R3 unsigned carry into HI");
  endtask

  task automatic t_acc;
    run_op(3'd2, 32'hFFFF_FFFB, 32'd3, 0, "R4 signed madd negative");
    run_op(3'd2, 32'h0001_0000, 32'h0001_0000, 0, "R4 signed madd positive");
    run_op(3'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R5 unsigned madd");
    move(1'b1, 32'hFFFF_FFFF, "R10 move HI idle");
    move(1'b0, 32'hFFFF_FFFF, "R10 move LO idle");
    run_op(3'd3, 32'd1, 32'd1, 0, "R5 unsigned madd wraps to zero");
    run_op(3'd5, 32'd1, 32'd1, 0, "R7 unsigned msub wraps below zero");
    run_op(3'd4, 32'hFFFF_FFFB, 32'd3, 0, "R6 signed msub negative product");
    run_op(3'd5, 32'hFFFF_FFFF, 32'd2, 0, "R7 unsigned msub large");
    run_op(3'd4, 32'd1000, 32'd1000, 0, "R6 signed msub positive");
  endtask

  task automatic t_intrude;
    move(1'b1, 32'h0000_0010, "R10 move HI before busy test");
    move(1'b0, 32'h0000_0020, "R10 move LO before busy test");
    run_op(3'd2, 32'd5, 32'd6, 2, "R10 move during busy discarded");
    run_op(3'd3, 32'd9, 32'd9, 1, "R9 restart during busy ignored");
  endtask

  task automatic t_reserved;
    for (int c = 6; c <= 7; c++) begin
      logic [63:0] held;
      held = {hi, lo};
      @(negedge clk);
      op = 3'(c); opa = 32'd3; opb = 32'd3; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy === 1'b0, "R11 reserved opcode no busy", {63'd0, busy}, 64'd0);
      for (int k = 0; k < LAT + 1; k++) begin
        @(negedge clk);
        chk(done === 1'b0 && {hi, lo} === held, "R11 reserved opcode no effect",
            {hi, lo}, held);
      end
    end
  endtask

  initial begin
    t_reset();
    t_mul();
    t_acc();
    t_intrude();
    t_reserved();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule